// File: doc/BRIEF.md
# Line Segment Length Sorter

This block collects finite line segments for one video frame and, on command, reorders them so that the longest segment comes first. Each segment carries a start position, an end position and an unsigned length. Segments are appended to an unsorted source table in the order they arrive. This order follows the angle and distance parameters used to find the segments.

A sort command starts a selection sort between two tables of equal size. Each pass walks the filled part of the source table one slot per clock. The pass remembers the longest segment that is still marked present. It then copies that segment into the next free slot of the destination table and marks it absent in the source. Passes continue until every segment has been moved. At that point the source is empty and ready for the next frame, and the destination holds the frame's segments in descending length order. The destination can be read by index at any time, through a port with one cycle of latency.

Top module: `line_sort_table`

## Requirements
- R1: While idle, a write with `wr_en` high appends the segment at the next free source slot, so segments keep their arrival order.
- R2: A write presented while `busy` is high is refused and leaves the source table unchanged.
- R3: Once the source holds DEPTH segments, further writes are refused and the next sort reports exactly DEPTH segments.
- R4: After a sort, destination index 0 holds the longest segment, and the indices that follow hold segments of non-increasing length. Each segment keeps its own start and end position.
- R5: When segments have equal length, the one that arrived earlier gets the lower destination index.
- R6: With n > 0 segments, `busy` rises at the clock edge that samples `sort_go` and stays high for exactly n*(n+1) cycles. Each pass costs n scan cycles and one move cycle. `done` is high for one cycle as `busy` falls.
- R7: A sort command with an empty source raises `done` at the edge that samples it, reports a count of 0, and never raises `busy`.
- R8: At each `done`, `line_count` takes the number of sorted segments. It holds that value until the next `done`, and resets to 0.
- R9: When a sort finishes, the source is empty. The next frame's writes start again at slot 0, and its sort returns only the new segments.
- R10: `rd_idx` is sampled at a clock edge, and the destination entry at that index appears on the read outputs after that edge. After reset, `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Append a segment to the source table |
| wr_start | input | POS_W | Start position of the written segment |
| wr_end | input | POS_W | End position of the written segment |
| wr_len | input | LEN_W | Unsigned length of the written segment |
| sort_go | input | 1 | Start sorting the source table (ignored while busy) |
| busy | output | 1 | Sort in progress; writes are refused |
| done | output | 1 | One-cycle strobe when a sort completes |
| line_count | output | CNT_W | Number of segments delivered by the last sort |
| rd_idx | input | IDX_W | Destination table read index |
| rd_start | output | POS_W | Start position at the read index |
| rd_end | output | POS_W | End position at the read index |
| rd_len | output | LEN_W | Length at the read index |

## Verification
The sort command is sampled at one edge, called E0. The bench then counts clock edges until `done` appears and expects exactly n*(n+1) of them. It checks `busy` at the first falling edge after E0 and checks that `done` has dropped again one cycle later. Read results are due one edge after the index is sampled. The bench therefore registers each read request at the rising edge and compares the data against a queue of expected segments at the following falling edge. The expected queue is built with a stable longest-first selection over the bench's own copy of the accepted writes. Writes refused while busy or while the table is full are left out of that copy, so any leakage of a refused write shows up as a wrong count.

// File: rtl/lts_pkg.sv
package lts_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SCAN = 2'd1,
      ST_MOVE = 2'd2
   } lts_state_t;
endpackage

// File: rtl/lts_src_table.sv
module lts_src_table #(
   parameter int DEPTH = 256,
   parameter int POS_W = 20,
   parameter int LEN_W = 10,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [POS_W-1:0] wr_start,
   input  logic [POS_W-1:0] wr_end,
   input  logic [LEN_W-1:0] wr_len,
   input  logic             clr_en,
   input  logic [IDX_W-1:0] clr_idx,
   input  logic [IDX_W-1:0] scan_idx,
   output logic             scan_valid,
   output logic [LEN_W-1:0] scan_len,
   input  logic [IDX_W-1:0] sel_idx,
   output logic [POS_W-1:0] sel_start,
   output logic [POS_W-1:0] sel_end,
   output logic [LEN_W-1:0] sel_len
);
   logic [POS_W-1:0] start_q [DEPTH];
   logic [POS_W-1:0] end_q   [DEPTH];
   logic [LEN_W-1:0] len_q   [DEPTH];
   logic [DEPTH-1:0] present;

   always_ff @(posedge clk) begin
      if (wr_en) begin
         start_q[wr_idx] <= wr_start;
         end_q[wr_idx]   <= wr_end;
         len_q[wr_idx]   <= wr_len;
      end
   end

   // one presence flag per slot
   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic here_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                here_q <= 1'b0;
         else if (wr_en  && wr_idx  == IDX_W'(g))   here_q <= 1'b1;
         else if (clr_en && clr_idx == IDX_W'(g))   here_q <= 1'b0;
      end
      assign present[g] = here_q;
   end

   assign scan_valid = present[scan_idx];
   assign scan_len   = len_q[scan_idx];
   assign sel_start  = start_q[sel_idx];
   assign sel_end    = end_q[sel_idx];
   assign sel_len    = len_q[sel_idx];
endmodule

// File: rtl/lts_max_scan.sv
module lts_max_scan #(
   parameter int IDX_W = 8,
   parameter int LEN_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             step_en,
   input  logic [IDX_W-1:0] step_idx,
   input  logic             step_valid,
   input  logic [LEN_W-1:0] step_len,
   output logic [IDX_W-1:0] best_idx
);
   logic             found_q;
   logic [LEN_W-1:0] best_len_q;
   logic             take;

   // strict compare keeps the earliest of equal lengths
   assign take = step_en && step_valid && (!found_q || step_len > best_len_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         found_q    <= 1'b0;
         best_len_q <= '0;
         best_idx   <= '0;
      end else if (clear) begin
         found_q    <= 1'b0;
         best_len_q <= '0;
      end else if (take) begin
         found_q    <= 1'b1;
         best_len_q <= step_len;
         best_idx   <= step_idx;
      end
   end
endmodule

// File: rtl/lts_dst_table.sv
module lts_dst_table #(
   parameter int DEPTH = 256,
   parameter int POS_W = 20,
   parameter int LEN_W = 10,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [POS_W-1:0] wr_start,
   input  logic [POS_W-1:0] wr_end,
   input  logic [LEN_W-1:0] wr_len,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [POS_W-1:0] rd_start,
   output logic [POS_W-1:0] rd_end,
   output logic [LEN_W-1:0] rd_len
);
   logic [POS_W-1:0] start_q [DEPTH];
   logic [POS_W-1:0] end_q   [DEPTH];
   logic [LEN_W-1:0] len_q   [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         start_q[wr_idx] <= wr_start;
         end_q[wr_idx]   <= wr_end;
         len_q[wr_idx]   <= wr_len;
      end
      rd_start <= start_q[rd_idx];
      rd_end   <= end_q[rd_idx];
      rd_len   <= len_q[rd_idx];
   end
endmodule

// File: rtl/line_sort_table.sv
module line_sort_table
   import lts_pkg::*;
#(
   parameter int DEPTH = 256,
   parameter int POS_W = 20,
   parameter int LEN_W = 10,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [POS_W-1:0] wr_start,
   input  logic [POS_W-1:0] wr_end,
   input  logic [LEN_W-1:0] wr_len,
   input  logic             sort_go,
   output logic             busy,
   output logic             done,
   output logic [CNT_W-1:0] line_count,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [POS_W-1:0] rd_start,
   output logic [POS_W-1:0] rd_end,
   output logic [LEN_W-1:0] rd_len
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("line_sort_table: DEPTH must be at least 2");
   end
   if (POS_W < 1 || LEN_W < 1) begin : g_bad_width
      $error("line_sort_table: POS_W and LEN_W must be positive");
   end

   lts_state_t       state_q;
   logic [CNT_W-1:0] fill_q;
   logic [IDX_W-1:0] scan_q;
   logic [CNT_W-1:0] put_q;
   logic             done_q;
   logic [CNT_W-1:0] count_q;

   logic             wr_take;
   logic             last_scan;
   logic             last_put;
   logic             in_scan;
   logic             in_move;
   logic             scan_clear;
   logic             scan_valid;
   logic [LEN_W-1:0] scan_len;
   logic [IDX_W-1:0] best_idx;
   logic [POS_W-1:0] sel_start;
   logic [POS_W-1:0] sel_end;
   logic [LEN_W-1:0] sel_len;

   assign in_scan    = (state_q == ST_SCAN);
   assign in_move    = (state_q == ST_MOVE);
   assign wr_take    = wr_en && (state_q == ST_IDLE) && !sort_go && (fill_q < CNT_W'(DEPTH));
   assign last_scan  = (CNT_W'(scan_q) == fill_q - CNT_W'(1));
   assign last_put   = (put_q + CNT_W'(1) == fill_q);
   assign scan_clear = ((state_q == ST_IDLE) && sort_go) || in_move;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         fill_q  <= '0;
         scan_q  <= '0;
         put_q   <= '0;
         done_q  <= 1'b0;
         count_q <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (sort_go) begin
                  if (fill_q == '0) begin
                     done_q  <= 1'b1;
                     count_q <= '0;
                  end else begin
                     state_q <= ST_SCAN;
                     scan_q  <= '0;
                     put_q   <= '0;
                  end
               end else if (wr_take) begin
                  fill_q <= fill_q + CNT_W'(1);
               end
            end
            ST_SCAN: begin
               if (last_scan) state_q <= ST_MOVE;
               else           scan_q  <= scan_q + IDX_W'(1);
            end
            ST_MOVE: begin
               scan_q <= '0;
               put_q  <= put_q + CNT_W'(1);
               if (last_put) begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
                  count_q <= fill_q;
                  fill_q  <= '0;
               end else begin
                  state_q <= ST_SCAN;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   lts_src_table #(.DEPTH(DEPTH), .POS_W(POS_W), .LEN_W(LEN_W)) u_src (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_take),
      .wr_idx     (fill_q[IDX_W-1:0]),
      .wr_start   (wr_start),
      .wr_end     (wr_end),
      .wr_len     (wr_len),
      .clr_en     (in_move),
      .clr_idx    (best_idx),
      .scan_idx   (scan_q),
      .scan_valid (scan_valid),
      .scan_len   (scan_len),
      .sel_idx    (best_idx),
      .sel_start  (sel_start),
      .sel_end    (sel_end),
      .sel_len    (sel_len)
   );

   lts_max_scan #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_scan (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (scan_clear),
      .step_en    (in_scan),
      .step_idx   (scan_q),
      .step_valid (scan_valid),
      .step_len   (scan_len),
      .best_idx   (best_idx)
   );

   lts_dst_table #(.DEPTH(DEPTH), .POS_W(POS_W), .LEN_W(LEN_W)) u_dst (
      .clk      (clk),
      .wr_en    (in_move),
      .wr_idx   (put_q[IDX_W-1:0]),
      .wr_start (sel_start),
      .wr_end   (sel_end),
      .wr_len   (sel_len),
      .rd_idx   (rd_idx),
      .rd_start (rd_start),
      .rd_end   (rd_end),
      .rd_len   (rd_len)
   );

   assign busy       = (state_q != ST_IDLE);
   assign done       = done_q;
   assign line_count = count_q;
endmodule

// File: rtl/lts_chk.sv
module lts_chk #(
   parameter int DEPTH = 256,
   parameter int CNT_W = 9
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sort_go,
   input logic             busy,
   input logic             done,
   input logic [CNT_W-1:0] fill,
   input logic [CNT_W-1:0] put,
   input logic [CNT_W-1:0] count
);
   p_no_write_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (fill == $past(fill)) || (fill == '0));

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= CNT_W'(DEPTH));

   p_put_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> put < fill);

   p_start_on_go_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(sort_go));

   p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   p_count_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> count == $past(fill));

   p_source_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> fill == '0);
endmodule

bind line_sort_table lts_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_lts_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .sort_go (sort_go),
   .busy    (busy),
   .done    (done),
   .fill    (fill_q),
   .put     (put_q),
   .count   (count_q)
);

// File: tb/line_sort_table_bench.sv
module line_sort_table_bench;
   localparam int DEPTH = 256;
   localparam int POS_W = 20;
   localparam int LEN_W = 10;
   localparam int IDX_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH + 1);

   typedef struct {
      logic [POS_W-1:0] s;
      logic [POS_W-1:0] e;
      logic [LEN_W-1:0] l;
   } seg_t;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             wr_en = 1'b0;
   logic [POS_W-1:0] wr_start = '0;
   logic [POS_W-1:0] wr_end = '0;
   logic [LEN_W-1:0] wr_len = '0;
   logic             sort_go = 1'b0;
   logic             busy;
   logic             done;
   logic [CNT_W-1:0] line_count;
   logic [IDX_W-1:0] rd_idx = '0;
   logic [POS_W-1:0] rd_start;
   logic [POS_W-1:0] rd_end;
   logic [LEN_W-1:0] rd_len;

   int   n_chk = 0;
   int   n_bad = 0;
   bit   rd_req = 1'b0;
   bit   rd_pend = 1'b0;
   seg_t src_q[$];
   seg_t exp_q[$];

   always #4 clk = ~clk;

   line_sort_table #(.DEPTH(DEPTH), .POS_W(POS_W), .LEN_W(LEN_W)) u_line_sort_table (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_start(wr_start), .wr_end(wr_end),
      .wr_len(wr_len), .sort_go(sort_go), .busy(busy), .done(done),
      .line_count(line_count), .rd_idx(rd_idx), .rd_start(rd_start),
      .rd_end(rd_end), .rd_len(rd_len)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // monitor: read data is due one edge after the index is sampled
   always @(posedge clk) rd_pend <= rd_req;
   always @(negedge clk) begin
      if (rd_pend) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R10 unexpected read", 0, 1);
         end else begin
            seg_t x;
            x = exp_q.pop_front();
            chk(rd_len == x.l, "R4/R5 length order", rd_len, x.l);
            chk(rd_start == x.s && rd_end == x.e, "R1/R5 segment identity", rd_start, x.s);
         end
      end
   end

   task automatic put(input int s, input int e, input int l, input bit taken);
      @(negedge clk);
      wr_en = 1'b1; wr_start = POS_W'(s); wr_end = POS_W'(e); wr_len = LEN_W'(l);
      @(negedge clk);
      wr_en = 1'b0;
      if (taken) src_q.push_back('{POS_W'(s), POS_W'(e), LEN_W'(l)});
   endtask

   // driver: stable longest-first selection of the accepted writes
   task automatic build_expect();
      while (src_q.size() > 0) begin
         int b = 0;
         for (int i = 1; i < src_q.size(); i++)
            if (src_q[i].l > src_q[b].l) b = i;
         exp_q.push_back(src_q[b]);
         src_q.delete(b);
      end
   endtask

   task automatic run_sort(input bit poke_busy);
      int n = src_q.size();
      int cyc = 0;
      build_expect();
      @(negedge clk); sort_go = 1'b1;
      @(negedge clk); sort_go = 1'b0;
      chk(busy == (n > 0), "R6/R7 busy after go", busy, n > 0);
      while (!done && cyc < 70000) begin
         wr_en = (poke_busy && cyc == 3);
         wr_start = 20'hABCDE; wr_end = 20'h12345; wr_len = 10'd1023;
         @(negedge clk);
         cyc++;
      end
      wr_en = 1'b0;
      chk(cyc == n * (n + 1), "R6/R7 sort duration", cyc, n * (n + 1));
      chk(done == 1'b1, "R6 done strobe", done, 1);
      chk(busy == 1'b0, "R6 busy low at done", busy, 0);
      chk(line_count == CNT_W'(n), "R8 count at done", line_count, n);
      @(negedge clk);
      chk(done == 1'b0, "R6 done one cycle", done, 0);
      for (int i = 0; i < n; i++) begin
         rd_idx = IDX_W'(i); rd_req = 1'b1;
         @(negedge clk);
      end
      rd_req = 1'b0;
      @(negedge clk); @(negedge clk);
      chk(exp_q.size() == 0, "R10 all reads returned", exp_q.size(), 0);
      chk(line_count == CNT_W'(n), "R8 count held", line_count, n);
   endtask

   initial begin
      #(8 * 190000);
      chk(1'b0, "watchdog", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 1'b0, "R10 reset busy", busy, 0);
      chk(done == 1'b0, "R10 reset done", done, 0);
      chk(line_count == '0, "R8 reset count", line_count, 0);

      // R7: empty sort
      run_sort(1'b0);

      // R1 R4 R2: distinct lengths, write poked while busy
      put(10, 110, 40, 1); put(11, 111, 700, 1); put(12, 112, 3, 1);
      put(13, 113, 512, 1); put(14, 114, 90, 1);
      run_sort(1'b1);
      // R2 R9: refused write must not appear in the next frame
      run_sort(1'b0);

      // R5 R9: ties, new frame starts at slot 0
      put(20, 220, 55, 1); put(21, 221, 80, 1); put(22, 222, 55, 1);
      put(23, 223, 80, 1); put(24, 224, 0, 1); put(25, 225, 55, 1);
      run_sort(1'b0);

      // R3: fill completely, one extra write refused
      for (int i = 0; i < DEPTH; i++)
         put(1000 + i, 5000 + 3 * i, (i == 100) ? 1023 : (i * 7) % 50, 1);
      put(99999, 88888, 1023, 0);
      run_sort(1'b0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule